// File: doc/BRIEF.md
# Receiver Lane Bring-Up Sequencer

This block powers up a serial camera-style physical-layer receiver after a single start request. At start it captures how many data lanes are in use (1 to 4), the line rate in Mbps and a per-step hold length. The rate goes through an ascending range table, which yields a 6-bit frequency band code.

The sequencer then works through a fixed script. First it sets up the lane control outputs. Next it raises the test clock and drives a timed clear pulse on the test port. Last, it issues seven register writes over the test port, each in two phases. One of these writes carries the band code. A one-cycle done pulse ends the sequence.

Every intermediate step is held for a programmable number of system clocks. This gives the receiver stable levels at each step. The clear pulse and the settle time that follows it are each a fixed number of clocks, set by a parameter.

Top module: `dphy_rx_bringup`

## Requirements
- R1: After reset: busy, done, error, lane enable, force-receive, turnaround request, turnaround disable, test clock, test clear, test enable and test data are all 0, and force-stop is all ones.
- R2: A start with a lane count of 0 or above NLANE (4) raises error for exactly one cycle. The block stays idle with busy low, and every control output keeps its value.
- R3: An accepted start sets force-receive, force-stop and turnaround request to 0 and turnaround disable to all ones. It sets lane enable to ones in bits [lanes-1:0] and zeros above. These values do not change while busy is high.
- R4: The band code is the code of the first table entry, in ascending order of upper bound, whose bound is at least the rate. Examples: 0..89 gives 0x00, 90..99 gives 0x10, 100..109 gives 0x20, 110..129 gives 0x01, 449 gives 0x06, 450 gives 0x16, 800 gives 0x29, 1500 gives 0x3C. Any rate above 1500 gives 0x3C.
- R5: The test clock goes high before test clear. Test clear is then high for exactly CLR_CYC clocks. The first test-enable rise comes CLR_CYC + 2·H clocks after test clear falls.
- R6: Exactly seven writes are issued, as (code, data) in this order: (0x34, 0), (0x44, band<<1), (0x54, 0), (0x84, 0), (0x94, 0), (0x75, 0x04), (0x00, 0).
- R7: Each write runs through these phases in order: clock high, code on the data bus, enable high, clock low, enable low, data on the bus, clock high. The code is taken on the falling clock edge while enable is high. The data is taken on the next rising clock edge.
- R8: Each setup step and each write phase lasts H = max(hold, 1) clocks, where hold is captured at start. Done rises 51·H + 2·CLR_CYC clocks after the edge that accepts start.
- R9: Busy is high from the accepted start until done. Done is a one-cycle pulse issued as busy falls. A start while busy has no effect on timing, writes or lane enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| lanes_i | input | LW (3) | Number of active data lanes |
| rate_i | input | RATE_W (12) | Line rate in Mbps |
| hold_i | input | HOLD_W (8) | Clocks per step (0 treated as 1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse on a rejected lane count |
| lane_en_o | output | NLANE (4) | Lane enable mask |
| frc_rx_o | output | NLANE (4) | Force receive mode per lane |
| frc_stop_o | output | NLANE (4) | Force stop state per lane |
| turn_req_o | output | NLANE (4) | Turnaround request per lane |
| turn_dis_o | output | NLANE (4) | Turnaround disable per lane |
| tst_clk_o | output | 1 | Test port clock |
| tst_clr_o | output | 1 | Test port clear |
| tst_en_o | output | 1 | Test port enable (code phase) |
| tst_din_o | output | 8 | Test port data bus |

## Verification
The hardest case to reach is a start request that arrives in the middle of a sequence. It must be seen to have no effect at all: no restart, no change to the lane mask taken from its lane count, and no shift in the write timing. The stimulus pulses start with a different lane count about twenty clocks into a run. It then compares the done time, the write list and the lane mask against an undisturbed run, and watches busy for a long while afterwards to confirm no second sequence starts. The band table edges are reached by table vectors that sit exactly on and just past several upper bounds, including the saturating top.

// File: rtl/dphy_bu_pkg.sv
package dphy_bu_pkg;

   localparam int NBAND   = 39;
   localparam int BOUND_W = 11;
   localparam int NWR     = 7;
   localparam int NPH     = 7;

   // ascending upper bounds in Mbps; order is the search priority
   localparam logic [BOUND_W-1:0] BAND_TOP [NBAND] = '{
      11'd89,   11'd99,   11'd109,  11'd129,  11'd139,  11'd149,  11'd169,
      11'd179,  11'd199,  11'd219,  11'd239,  11'd249,  11'd269,  11'd299,
      11'd329,  11'd359,  11'd399,  11'd449,  11'd499,  11'd549,  11'd599,
      11'd649,  11'd699,  11'd749,  11'd799,  11'd849,  11'd899,  11'd949,
      11'd999,  11'd1049, 11'd1099, 11'd1149, 11'd1199, 11'd1249, 11'd1299,
      11'd1349, 11'd1399, 11'd1449, 11'd1500};

   localparam logic [5:0] BAND_CODE [NBAND] = '{
      6'h00, 6'h10, 6'h20, 6'h01, 6'h11, 6'h21, 6'h02,
      6'h12, 6'h22, 6'h03, 6'h13, 6'h23, 6'h04, 6'h14,
      6'h05, 6'h15, 6'h25, 6'h06, 6'h16, 6'h07, 6'h17,
      6'h08, 6'h18, 6'h09, 6'h19, 6'h29, 6'h39, 6'h0a,
      6'h1a, 6'h2a, 6'h3a, 6'h0b, 6'h1b, 6'h2b, 6'h3b,
      6'h0c, 6'h1c, 6'h2c, 6'h3c};

   typedef enum logic [2:0] {
      ST_IDLE, ST_CFG, ST_TCLK, ST_CLRH, ST_CLRL, ST_WR
   } bu_st_e;

   function automatic logic [7:0] wr_code(input logic [2:0] idx);
      case (idx)
         3'd0:    return 8'h34;
         3'd1:    return 8'h44;
         3'd2:    return 8'h54;
         3'd3:    return 8'h84;
         3'd4:    return 8'h94;
         3'd5:    return 8'h75;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] wr_data(input logic [2:0] idx,
                                          input logic [5:0] band);
      case (idx)
         3'd1:    return {1'b0, band, 1'b0};
         3'd5:    return 8'h04;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/dphy_bu_band.sv
module dphy_bu_band
   import dphy_bu_pkg::*;
#(
   parameter int RATE_W = 12
) (
   input  logic [RATE_W-1:0] rate_i,
   output logic [5:0]        band_o
);

   generate
      if (RATE_W < BOUND_W) begin : g_bad_w
         $error("dphy_bu_band: RATE_W must cover the largest table bound");
      end
   endgenerate

   // scan from the top so the lowest matching entry wins
   always_comb begin
      band_o = BAND_CODE[NBAND-1];
      for (int i = NBAND - 1; i >= 0; i--) begin
         if (rate_i <= RATE_W'(BAND_TOP[i])) band_o = BAND_CODE[i];
      end
   end

endmodule

// File: rtl/dphy_bu_timer.sv
module dphy_bu_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         zero_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/dphy_rx_bringup.sv
module dphy_rx_bringup
   import dphy_bu_pkg::*;
#(
   parameter int NLANE   = 4,
   parameter int RATE_W  = 12,
   parameter int HOLD_W  = 8,
   parameter int CLR_CYC = 12500,
   localparam int LW     = $clog2(NLANE + 1),
   localparam int TMR_W  = $clog2((CLR_CYC > (1 << HOLD_W)) ? CLR_CYC : (1 << HOLD_W)) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [LW-1:0]     lanes_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [NLANE-1:0]  lane_en_o,
   output logic [NLANE-1:0]  frc_rx_o,
   output logic [NLANE-1:0]  frc_stop_o,
   output logic [NLANE-1:0]  turn_req_o,
   output logic [NLANE-1:0]  turn_dis_o,
   output logic              tst_clk_o,
   output logic              tst_clr_o,
   output logic              tst_en_o,
   output logic [7:0]        tst_din_o
);

   generate
      if (NLANE < 1 || NLANE > 4) begin : g_bad_lanes
         $error("dphy_rx_bringup: NLANE must be 1..4");
      end
      if (CLR_CYC < 1) begin : g_bad_clr
         $error("dphy_rx_bringup: CLR_CYC must be positive");
      end
   endgenerate

   bu_st_e            st_q;
   logic [2:0]        idx_q, ph_q, ph_n;
   logic [5:0]        band_q, band_w;
   logic [HOLD_W-1:0] hold_q, hold_eff;
   logic [NLANE-1:0]  mask_w;
   logic              lanes_ok, go, adv, tmr_zero, tmr_ld;
   logic [TMR_W-1:0]  ld_val;

   dphy_bu_band #(.RATE_W(RATE_W)) u_band (
      .rate_i (rate_i),
      .band_o (band_w)
   );

   for (genvar l = 0; l < NLANE; l++) begin : g_mask
      assign mask_w[l] = (lanes_i > LW'(l));
   end

   assign lanes_ok = (lanes_i != '0) && (lanes_i <= LW'(NLANE));
   assign hold_eff = (hold_i == '0) ? HOLD_W'(1) : hold_i;
   assign go       = (st_q == ST_IDLE) && start_i && lanes_ok;
   assign adv      = (st_q != ST_IDLE) && tmr_zero;
   assign tmr_ld   = go || adv;
   assign ph_n     = ph_q + 3'd1;

   always_comb begin
      case (st_q)
         ST_TCLK, ST_CLRH: ld_val = TMR_W'(CLR_CYC - 1);
         default:          ld_val = TMR_W'(hold_q) - TMR_W'(1);
      endcase
      if (go) ld_val = TMR_W'(hold_eff) - TMR_W'(1);
   end

   dphy_bu_timer #(.W(TMR_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_ld),
      .load_val_i (ld_val),
      .zero_o     (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         idx_q      <= '0;
         ph_q       <= '0;
         band_q     <= '0;
         hold_q     <= HOLD_W'(1);
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         err_o      <= 1'b0;
         lane_en_o  <= '0;
         frc_rx_o   <= '0;
         frc_stop_o <= '1;
         turn_req_o <= '0;
         turn_dis_o <= '0;
         tst_clk_o  <= 1'b0;
         tst_clr_o  <= 1'b0;
         tst_en_o   <= 1'b0;
         tst_din_o  <= '0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (st_q == ST_IDLE) begin
            if (start_i && !lanes_ok) err_o <= 1'b1;
            if (go) begin
               st_q       <= ST_CFG;
               busy_o     <= 1'b1;
               band_q     <= band_w;
               hold_q     <= hold_eff;
               lane_en_o  <= mask_w;
               frc_rx_o   <= '0;
               frc_stop_o <= '0;
               turn_req_o <= '0;
               turn_dis_o <= '1;
            end
         end else if (adv) begin
            case (st_q)
               ST_CFG: begin
                  st_q      <= ST_TCLK;
                  tst_clk_o <= 1'b1;
               end
               ST_TCLK: begin
                  st_q      <= ST_CLRH;
                  tst_clr_o <= 1'b1;
               end
               ST_CLRH: begin
                  st_q      <= ST_CLRL;
                  tst_clr_o <= 1'b0;
               end
               ST_CLRL: begin
                  st_q      <= ST_WR;
                  idx_q     <= '0;
                  ph_q      <= '0;
                  tst_clk_o <= 1'b1;
               end
               ST_WR: begin
                  if (ph_q == 3'(NPH - 1)) begin
                     if (idx_q == 3'(NWR - 1)) begin
                        st_q   <= ST_IDLE;
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                     end else begin
                        idx_q     <= idx_q + 3'd1;
                        ph_q      <= '0;
                        tst_clk_o <= 1'b1;
                     end
                  end else begin
                     ph_q <= ph_n;
                     case (ph_n)
                        3'd1:    tst_din_o <= wr_code(idx_q);
                        3'd2:    tst_en_o  <= 1'b1;
                        3'd3:    tst_clk_o <= 1'b0;
                        3'd4:    tst_en_o  <= 1'b0;
                        3'd5:    tst_din_o <= wr_data(idx_q, band_q);
                        default: tst_clk_o <= 1'b1;
                     endcase
                  end
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/dphy_bu_chk.sv
module dphy_bu_chk #(
   parameter int NLANE   = 4,
   parameter int CLR_CYC = 12500
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             done_o,
   input logic             err_o,
   input logic [NLANE-1:0] lane_en_o,
   input logic             tst_clk_o,
   input logic             tst_clr_o,
   input logic             tst_en_o,
   input logic [7:0]       tst_din_o
);

   int unsigned clr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          clr_cnt <= 0;
      else if (tst_clr_o)  clr_cnt <= clr_cnt + 1;
      else                 clr_cnt <= 0;
   end

   assert_err_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o);
   assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(lane_en_o));
   assert_clr_under_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tst_clr_o |-> tst_clk_o);
   assert_clr_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tst_clr_o) |-> (clr_cnt == CLR_CYC));
   assert_en_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tst_en_o) |-> tst_clk_o);
   assert_code_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tst_clk_o) |-> ($stable(tst_din_o) && tst_en_o));
   assert_data_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tst_clk_o) |-> ($stable(tst_din_o) && !tst_en_o));
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

endmodule

bind dphy_rx_bringup dphy_bu_chk #(.NLANE(NLANE), .CLR_CYC(CLR_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .err_o     (err_o),
   .lane_en_o (lane_en_o),
   .tst_clk_o (tst_clk_o),
   .tst_clr_o (tst_clr_o),
   .tst_en_o  (tst_en_o),
   .tst_din_o (tst_din_o)
);

// File: tb/tb_dphy_rx_bringup.sv
module tb_dphy_rx_bringup;

   localparam int NLANE = 4;
   localparam int RATE_W = 12;
   localparam int HOLD_W = 8;
   localparam int C = 10;
   localparam int LW = 3;
   localparam int NV = 12;

   // {rate, lanes, hold, expected band}
   localparam logic [28:0] VEC [NV] = '{
      {12'd0,    3'd1, 8'd2, 6'h00},
      {12'd89,   3'd2, 8'd1, 6'h00},
      {12'd90,   3'd3, 8'd3, 6'h10},
      {12'd99,   3'd4, 8'd0, 6'h10},
      {12'd100,  3'd1, 8'd2, 6'h20},
      {12'd110,  3'd2, 8'd2, 6'h01},
      {12'd449,  3'd3, 8'd1, 6'h06},
      {12'd450,  3'd4, 8'd2, 6'h16},
      {12'd800,  3'd1, 8'd1, 6'h29},
      {12'd1500, 3'd2, 8'd2, 6'h3c},
      {12'd1501, 3'd3, 8'd1, 6'h3c},
      {12'd4095, 3'd4, 8'd2, 6'h3c}};

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
   logic [LW-1:0] lanes_i = '0;
   logic [RATE_W-1:0] rate_i = '0;
   logic [HOLD_W-1:0] hold_i = '0;
   logic busy_o, done_o, err_o, tst_clk_o, tst_clr_o, tst_en_o;
   logic [NLANE-1:0] lane_en_o, frc_rx_o, frc_stop_o, turn_req_o, turn_dis_o;
   logic [7:0] tst_din_o;

   int checks = 0, fails = 0, wd = 0;

   always #4 clk = ~clk;

   dphy_rx_bringup #(.NLANE(NLANE), .RATE_W(RATE_W), .HOLD_W(HOLD_W), .CLR_CYC(C)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lanes_i(lanes_i),
      .rate_i(rate_i), .hold_i(hold_i), .busy_o(busy_o), .done_o(done_o),
      .err_o(err_o), .lane_en_o(lane_en_o), .frc_rx_o(frc_rx_o),
      .frc_stop_o(frc_stop_o), .turn_req_o(turn_req_o), .turn_dis_o(turn_dis_o),
      .tst_clk_o(tst_clk_o), .tst_clr_o(tst_clr_o), .tst_en_o(tst_en_o),
      .tst_din_o(tst_din_o));

   // port-level monitor, sampled on falling clock
   int cyc = 0, wr_cnt = 0, done_cyc = -1, done_n = 0;
   int clr_rise = 0, clr_w = -1, clr_fall = -1, gap = -1;
   logic [7:0] codes [8];
   logic [7:0] datas [8];
   logic [7:0] pcode = '0;
   bit pend = 0, p_clk = 0, p_en = 0, p_clr = 0;

   always @(negedge clk) begin
      if (start_i && !busy_o && rst_n) begin
         cyc = 0; wr_cnt = 0; done_cyc = -1; clr_w = -1; clr_fall = -1; gap = -1; pend = 0;
      end else begin
         cyc++;
      end
      if (p_clk && !tst_clk_o && tst_en_o) begin pcode = tst_din_o; pend = 1; end
      if (!p_clk && tst_clk_o && pend) begin
         if (wr_cnt < 8) begin codes[wr_cnt] = pcode; datas[wr_cnt] = tst_din_o; end
         wr_cnt++; pend = 0;
      end
      if (!p_clr && tst_clr_o) clr_rise = cyc;
      if (p_clr && !tst_clr_o) begin clr_w = cyc - clr_rise; clr_fall = cyc; end
      if (!p_en && tst_en_o && gap < 0 && clr_fall >= 0) gap = cyc - clr_fall;
      if (done_o) begin done_n++; if (done_cyc < 0) done_cyc = cyc; end
      p_clk = tst_clk_o; p_en = tst_en_o; p_clr = tst_clr_o;
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_code(input int i);
      case (i) 0: return 8'h34; 1: return 8'h44; 2: return 8'h54; 3: return 8'h84;
               4: return 8'h94; 5: return 8'h75; default: return 8'h00; endcase
   endfunction

   task automatic run_vec(input int rate, input int lanes, input int hold,
                          input int band, input bit poke);
      int h, t, g;
      logic [7:0] ed;
      logic [NLANE-1:0] m;
      h = (hold == 0) ? 1 : hold;
      t = 51 * h + 2 * C;
      m = NLANE'((1 << lanes) - 1);
      @(posedge clk); #2;
      rate_i = RATE_W'(rate); lanes_i = LW'(lanes); hold_i = HOLD_W'(hold); start_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
      if (poke) begin
         repeat (20) @(posedge clk);
         #2; start_i = 1'b1; lanes_i = 3'd1; hold_i = 8'd5;
         @(posedge clk); #2; start_i = 1'b0;
      end
      g = 0;
      while (done_cyc < 0 && g < 3000) begin @(negedge clk); g++; end
      #1;
      chk(done_cyc == t + 1, "R8 done timing", done_cyc, t + 1);
      chk(!busy_o, "R9 busy clear at done", int'(busy_o), 0);
      chk(wr_cnt == 7, "R6 write count", wr_cnt, 7);
      for (int i = 0; i < 7; i++) begin
         ed = (i == 1) ? 8'(band << 1) : (i == 5) ? 8'h04 : 8'h00;
         chk(codes[i] == exp_code(i), "R6 R7 write code", int'(codes[i]), int'(exp_code(i)));
         chk(datas[i] == ed, (i == 1) ? "R4 band data" : "R6 R7 write data",
             int'(datas[i]), int'(ed));
      end
      chk(lane_en_o == m, "R3 lane mask", int'(lane_en_o), int'(m));
      chk(turn_dis_o == '1 && frc_rx_o == '0 && frc_stop_o == '0 && turn_req_o == '0,
          "R3 control levels", int'({turn_dis_o, frc_rx_o, frc_stop_o, turn_req_o}), 16'hF000);
      chk(clr_w == C, "R5 clear width", clr_w, C);
      chk(gap == C + 2 * h, "R5 clear to first write", gap, C + 2 * h);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd == 150000) begin
         checks++; fails++;
         $display("FAIL R9 watchdog expired actual=%0d expected<%0d", wd, 150000);
         summary();
      end
   end

   initial begin
      int n0;
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk(!busy_o && !done_o && !err_o, "R1 status", int'({busy_o, done_o, err_o}), 0);
      chk(lane_en_o == '0 && frc_rx_o == '0 && turn_req_o == '0 && turn_dis_o == '0,
          "R1 lane controls", int'({lane_en_o, frc_rx_o, turn_req_o, turn_dis_o}), 0);
      chk(frc_stop_o == '1, "R1 force stop", int'(frc_stop_o), 15);
      chk(!tst_clk_o && !tst_clr_o && !tst_en_o && tst_din_o == '0, "R1 test port",
          int'({tst_clk_o, tst_clr_o, tst_en_o, tst_din_o}), 0);
      rst_n = 1'b1;

      // R2 bad lane counts
      for (int k = 0; k < 2; k++) begin
         @(posedge clk); #2;
         lanes_i = (k == 0) ? 3'd0 : 3'd5; start_i = 1'b1;
         @(posedge clk); #2;
         start_i = 1'b0;
         chk(err_o && !busy_o, "R2 error pulse", int'({err_o, busy_o}), 2);
         @(posedge clk); #2;
         chk(!err_o && !busy_o, "R2 error one cycle, stays idle", int'({err_o, busy_o}), 0);
         chk(lane_en_o == '0 && frc_stop_o == '1 && !tst_clk_o, "R2 outputs untouched",
             int'({lane_en_o, frc_stop_o}), 8'h0F);
      end

      // table of vectors: R4 band lookup, R6/R7 write script, R8 timing
      for (int v = 0; v < NV; v++) begin
         run_vec(int'(VEC[v][28:17]), int'(VEC[v][16:14]), int'(VEC[v][13:6]),
                 int'(VEC[v][5:0]), 1'b0);
      end

      // R9 start while busy is ignored
      run_vec(450, 4, 2, 'h16, 1'b1);
      n0 = done_n;
      repeat (200) begin
         @(negedge clk);
         if (busy_o) break;
      end
      chk(!busy_o && done_n == n0, "R9 no restart after ignored start", int'(busy_o), 0);

      summary();
   end

endmodule